// File: doc/BRIEF.md
# Flash Page Buffer Loader

This block stages one page of program data, 128 words of 16 bits or 256 bytes, ahead of a flash program operation. A host fills it over one write strobe that carries a data word, a column address, a bank select and a byte/word mode flag. Two fill methods exist. A page-program command opens a strict burst: every following write is data, and its column must count up from zero to the last column of the page. A single-load command instead stores one datum at any column, and the host repeats it as needed.

When the page is complete, the block raises a transfer request toward the write state machine. A full burst raises it on its own; a buffer filled by single loads needs a flush command followed by a confirm. While the request is high, the engine reads the page word by word through a read index. It then acknowledges, and the buffer empties itself. A clear command followed by a confirm also empties the buffer. Any location that was never loaded reads as all-ones, so those cells are left unprogrammed.

Top module: `flash_pgbuf_loader`

## Requirements
- R1: After reset, xfer_req, seq_err and loading are 0, and every buffer word reads 16'hFFFF.
- R2: In word mode (byte_mode=0), a write of command 8'h41 sets loading. The next 128 writes must carry columns 0,1,...,127 in wr_col[6:0], and each stores wr_data at that word. xfer_req rises after the 128th write, and loading falls.
- R3: In byte mode (byte_mode=1), the burst takes 256 writes with wr_col counting from 0 to 255. The byte wr_data[7:0] goes to word wr_col[7:1]: the low byte when wr_col[0]=0 and the high byte when wr_col[0]=1.
- R4: A burst write whose column differs from the expected one sets seq_err. It also ends the burst (loading=0), empties the buffer and raises no xfer_req. The next 8'h41 command clears seq_err.
- R5: Command 8'h74 with wr_bank=0 makes the next write store one datum at its column, in either mode. With wr_bank=1 the command is ignored, and the following write is treated as a command.
- R6: A location that was never loaded reads 8'hFF in each unloaded byte. This includes the other half of a word that a byte-mode write touched only partly.
- R7: Command 8'h0E with wr_bank=0 followed by 8'hD0 raises xfer_req. Any other second write cancels the flush and keeps the contents. 8'h0E with wr_bank=1 is ignored.
- R8: xfer_req stays high until xfer_ack, and host writes are ignored meanwhile. One cycle with xfer_ack high drops xfer_req and empties the buffer.
- R9: Command 8'h55 followed by 8'hD0 empties the buffer. Any other second write leaves the buffer unchanged.
- R10: In idle, commands are decoded from wr_data[7:0] only. Any other code is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_bank | input | 1 | Bank of the write: 0 bank I, 1 bank II |
| byte_mode | input | 1 | 1 byte columns, 0 word columns |
| wr_col | input | 8 | Column address (byte column, or word column in bits 6:0) |
| wr_data | input | 16 | Command code in bits 7:0, or write data |
| xfer_req | output | 1 | Page ready for the program engine |
| xfer_ack | input | 1 | Engine has taken the page |
| eng_idx | input | 7 | Word index read by the engine |
| eng_word | output | 16 | Buffer word at eng_idx, all-ones where not loaded |
| seq_err | output | 1 | Last burst aborted on a column mismatch |
| loading | output | 1 | Burst in progress |

## Verification
The bench checks the exact write that completes a burst: the request must be low after 127 words (or 255 bytes) and high after the last one. A counter that is off by one would show the request one write early or late. The bench places a mismatched column in the middle of a burst. A design that does not abort would keep loading, keep stale data or later raise a request. The single-load and flush commands are also issued on bank II, where a design that ignored the bank would store data or start a transfer. Clear and flush commands are followed by a non-confirm value to make sure neither acts on a wrong second write. A write is issued while the request is pending to make sure the page cannot change under the engine.

// File: rtl/pgbuf_pkg.sv
// Package: command codes and controller states shared by the page buffer.
// Assumes the command byte arrives in the low byte of the write data.
package pgbuf_pkg;
    localparam int          BYTE_W      = 8;
    localparam int          LANES       = 2;
    localparam logic [7:0]  CMD_BURST   = 8'h41;
    localparam logic [7:0]  CMD_SINGLE  = 8'h74;
    localparam logic [7:0]  CMD_FLUSH   = 8'h0E;
    localparam logic [7:0]  CMD_CLEAR   = 8'h55;
    localparam logic [7:0]  CMD_CONFIRM = 8'hD0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BURST,
        ST_SINGLE,
        ST_FLUSH_CF,
        ST_CLEAR_CF,
        ST_XFER
    } pgbuf_state_e;
endpackage

// File: rtl/pgbuf_store.sv
// Module: byte-lane storage with one valid bit per byte.
// Each lane has its own memory and valid mask; unloaded bytes read as 8'hFF.
// Assumes wr and clr are never high together (the controller keeps them apart).
module pgbuf_store
    import pgbuf_pkg::*;
#(
    parameter int WORDS = 128,
    parameter int IDX_W = $clog2(WORDS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr,
    input  logic                      clr,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [LANES-1:0]          wr_mask,
    input  logic [LANES*BYTE_W-1:0]   wr_data,
    input  logic [IDX_W-1:0]          rd_idx,
    output logic [LANES*BYTE_W-1:0]   rd_word
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] mem [WORDS];
        logic [WORDS-1:0]  vld;

        // Track which bytes of this lane hold loaded data.
        always_ff @(posedge clk) begin
            if (!rst_n)                 vld <= '0;
            else if (clr)               vld <= '0;
            else if (wr && wr_mask[g])  vld[wr_idx] <= 1'b1;
        end

        // Store the incoming byte of this lane.
        always_ff @(posedge clk) begin
            if (wr && wr_mask[g]) mem[wr_idx] <= wr_data[g*BYTE_W +: BYTE_W];
        end

        // Read port: return all-ones for bytes that were never loaded.
        assign rd_word[g*BYTE_W +: BYTE_W] = vld[rd_idx] ? mem[rd_idx] : {BYTE_W{1'b1}};
    end

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !wr) |=> (rd_word == '1));                                 // R9
    AST_WR_CLR_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && clr));                                                     // R8
endmodule

// File: rtl/pgbuf_seq.sv
// Module: command decoder and fill controller for the page buffer.
// Decodes commands in idle, runs the incrementing burst, handles single
// loads, the flush and clear confirm pairs, and the transfer handshake.
// Assumes byte_mode stays stable for the length of a burst.
module pgbuf_seq
    import pgbuf_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     wr_bank,
    input  logic                     byte_mode,
    input  logic [IDX_W:0]           wr_col,
    input  logic [LANES*BYTE_W-1:0]  wr_data,
    input  logic                     xfer_ack,
    output logic                     st_wr,
    output logic                     st_clr,
    output logic [IDX_W-1:0]         st_idx,
    output logic [LANES-1:0]         st_mask,
    output logic [LANES*BYTE_W-1:0]  st_data,
    output logic                     xfer_req,
    output logic                     seq_err,
    output logic                     loading
);
    pgbuf_state_e   state, nxt;
    logic [IDX_W:0] exp_col;
    logic [IDX_W:0] last_col;
    logic [7:0]     cmd;
    logic           col_match;
    logic           burst_start;

    assign cmd         = wr_data[7:0];
    assign last_col    = byte_mode ? {(IDX_W+1){1'b1}} : {1'b0, {IDX_W{1'b1}}};
    assign col_match   = byte_mode ? (wr_col == exp_col)
                                   : ({1'b0, wr_col[IDX_W-1:0]} == exp_col);
    assign burst_start = (state == ST_IDLE) && wr_en && (cmd == CMD_BURST);

    // Map the column to a word index, a lane mask and the lane data.
    always_comb begin
        st_idx  = byte_mode ? wr_col[IDX_W:1] : wr_col[IDX_W-1:0];
        st_mask = byte_mode ? (wr_col[0] ? 2'b10 : 2'b01) : 2'b11;
        st_data = byte_mode ? {2{wr_data[7:0]}} : wr_data;
    end

    // Next-state logic with the store write and clear strobes.
    always_comb begin
        nxt    = state;
        st_wr  = 1'b0;
        st_clr = 1'b0;
        case (state)
            ST_IDLE: if (wr_en) begin
                case (cmd)
                    CMD_BURST:  nxt = ST_BURST;
                    CMD_SINGLE: if (!wr_bank) nxt = ST_SINGLE;
                    CMD_FLUSH:  if (!wr_bank) nxt = ST_FLUSH_CF;
                    CMD_CLEAR:  nxt = ST_CLEAR_CF;
                    default:    nxt = ST_IDLE;
                endcase
            end
            ST_BURST: if (wr_en) begin
                if (col_match) begin
                    st_wr = 1'b1;
                    if (exp_col == last_col) nxt = ST_XFER;
                end else begin
                    st_clr = 1'b1;
                    nxt    = ST_IDLE;
                end
            end
            ST_SINGLE: if (wr_en) begin
                st_wr = 1'b1;
                nxt   = ST_IDLE;
            end
            ST_FLUSH_CF: if (wr_en) begin
                nxt = (cmd == CMD_CONFIRM) ? ST_XFER : ST_IDLE;
            end
            ST_CLEAR_CF: if (wr_en) begin
                st_clr = (cmd == CMD_CONFIRM);
                nxt    = ST_IDLE;
            end
            ST_XFER: if (xfer_ack) begin
                st_clr = 1'b1;
                nxt    = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Expected burst column: zero at burst start, then one step per accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)                             exp_col <= '0;
        else if (burst_start)                   exp_col <= '0;
        else if (state == ST_BURST && st_wr)    exp_col <= exp_col + 1'b1;
    end

    // Sequence error flag: set on a burst mismatch, cleared by a new burst.
    always_ff @(posedge clk) begin
        if (!rst_n)                                         seq_err <= 1'b0;
        else if (burst_start)                               seq_err <= 1'b0;
        else if (state == ST_BURST && wr_en && !col_match)  seq_err <= 1'b1;
    end

    assign xfer_req = (state == ST_XFER);
    assign loading  = (state == ST_BURST);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_ack) |=> xfer_req);                             // R8
    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && xfer_ack) |=> !xfer_req);                             // R8
    AST_ERR_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_err) |-> (!loading && !xfer_req && $past(loading)));     // R4
    AST_REQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_req) |-> ($past(loading) || $past(state == ST_FLUSH_CF))); // R7
endmodule

// File: rtl/flash_pgbuf_loader.sv
// Module: top of the flash page buffer loader.
// Joins the fill controller to the byte-lane storage and gives the
// program engine a word read port. Assumes one host write per strobe cycle.
module flash_pgbuf_loader
    import pgbuf_pkg::*;
#(
    parameter int WORDS = 128,
    parameter int IDX_W = $clog2(WORDS),
    parameter int COL_W = IDX_W + 1,
    parameter int DW    = LANES * BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_bank,
    input  logic             byte_mode,
    input  logic [COL_W-1:0] wr_col,
    input  logic [DW-1:0]    wr_data,
    output logic             xfer_req,
    input  logic             xfer_ack,
    input  logic [IDX_W-1:0] eng_idx,
    output logic [DW-1:0]    eng_word,
    output logic             seq_err,
    output logic             loading
);
    logic             st_wr;
    logic             st_clr;
    logic [IDX_W-1:0] st_idx;
    logic [LANES-1:0] st_mask;
    logic [DW-1:0]    st_data;

    pgbuf_seq #(.IDX_W(IDX_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_bank   (wr_bank),
        .byte_mode (byte_mode),
        .wr_col    (wr_col),
        .wr_data   (wr_data),
        .xfer_ack  (xfer_ack),
        .st_wr     (st_wr),
        .st_clr    (st_clr),
        .st_idx    (st_idx),
        .st_mask   (st_mask),
        .st_data   (st_data),
        .xfer_req  (xfer_req),
        .seq_err   (seq_err),
        .loading   (loading)
    );

    pgbuf_store #(.WORDS(WORDS), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (st_wr),
        .clr     (st_clr),
        .wr_idx  (st_idx),
        .wr_mask (st_mask),
        .wr_data (st_data),
        .rd_idx  (eng_idx),
        .rd_word (eng_word)
    );
endmodule

// File: tb/flash_pgbuf_loader_tb.sv
// Directed bench for the page buffer loader: one task per scenario.
module flash_pgbuf_loader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_bank = 1'b0;
    logic        byte_mode = 1'b0;
    logic [7:0]  wr_col = '0;
    logic [15:0] wr_data = '0;
    logic        xfer_req;
    logic        xfer_ack = 1'b0;
    logic [6:0]  eng_idx = '0;
    logic [15:0] eng_word;
    logic        seq_err;
    logic        loading;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    flash_pgbuf_loader u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank),
        .byte_mode(byte_mode), .wr_col(wr_col), .wr_data(wr_data),
        .xfer_req(xfer_req), .xfer_ack(xfer_ack), .eng_idx(eng_idx),
        .eng_word(eng_word), .seq_err(seq_err), .loading(loading)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] d, input logic [7:0] col, input logic bank);
        wr_en = 1'b1; wr_data = d; wr_col = col; wr_bank = bank;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ack();
        xfer_ack = 1'b1;
        @(negedge clk);
        xfer_ack = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int idx, input logic [15:0] exp);
        eng_idx = idx[6:0];
        #1;
        chk(tag, eng_word, exp);
    endtask

    task automatic t_reset();
        chk("R1 xfer_req", {15'd0, xfer_req}, 16'd0);
        chk("R1 seq_err", {15'd0, seq_err}, 16'd0);
        chk("R1 loading", {15'd0, loading}, 16'd0);
        rd_chk("R1 word 5 empty", 5, 16'hFFFF);
        rd_chk("R6 word 127 empty", 127, 16'hFFFF);
    endtask

    task automatic t_word_burst();
        byte_mode = 1'b0;
        wr(16'h0041, 8'h00, 1'b0);
        chk("R2 loading after 41", {15'd0, loading}, 16'd1);
        for (int i = 0; i < 128; i++) begin
            wr(16'hA000 + 16'(i), 8'(i), 1'b0);
            if (i == 126) chk("R2 no req before last", {15'd0, xfer_req}, 16'd0);
        end
        chk("R2 req after last", {15'd0, xfer_req}, 16'd1);
        chk("R2 loading off", {15'd0, loading}, 16'd0);
        rd_chk("R2 word 0", 0, 16'hA000);
        rd_chk("R2 word 77", 77, 16'hA04D);
        rd_chk("R2 word 127", 127, 16'hA07F);
        wr(16'h0074, 8'h00, 1'b0);
        wr(16'h5555, 8'h03, 1'b0);
        rd_chk("R8 write ignored during req", 3, 16'hA003);
        chk("R8 req held", {15'd0, xfer_req}, 16'd1);
        ack();
        chk("R8 req dropped", {15'd0, xfer_req}, 16'd0);
        rd_chk("R8 emptied after ack", 0, 16'hFFFF);
    endtask

    task automatic t_byte_burst();
        byte_mode = 1'b1;
        wr(16'h0041, 8'h00, 1'b0);
        for (int i = 0; i < 256; i++) begin
            wr({8'h00, 8'(i) ^ 8'h5A}, 8'(i), 1'b0);
            if (i == 254) chk("R3 no req at 255", {15'd0, xfer_req}, 16'd0);
        end
        chk("R3 req after 256", {15'd0, xfer_req}, 16'd1);
        rd_chk("R3 word 0", 0, {8'h01 ^ 8'h5A, 8'h00 ^ 8'h5A});
        rd_chk("R3 word 100", 100, {8'd201 ^ 8'h5A, 8'd200 ^ 8'h5A});
        ack();
        byte_mode = 1'b0;
    endtask

    task automatic t_seq_err();
        wr(16'h0041, 8'h00, 1'b0);
        wr(16'h1111, 8'h00, 1'b0);
        wr(16'h2222, 8'h01, 1'b0);
        wr(16'h3333, 8'h05, 1'b0);
        chk("R4 seq_err set", {15'd0, seq_err}, 16'd1);
        chk("R4 burst ended", {15'd0, loading}, 16'd0);
        chk("R4 no req", {15'd0, xfer_req}, 16'd0);
        rd_chk("R4 buffer emptied", 0, 16'hFFFF);
        wr(16'h0041, 8'h00, 1'b0);
        chk("R4 seq_err cleared by 41", {15'd0, seq_err}, 16'd0);
        wr(16'h4444, 8'h02, 1'b0);
        chk("R4 error at first write", {15'd0, seq_err}, 16'd1);
    endtask

    task automatic t_single();
        byte_mode = 1'b0;
        wr(16'h0074, 8'h00, 1'b0);
        wr(16'h1234, 8'h0A, 1'b0);
        rd_chk("R5 single load word 10", 10, 16'h1234);
        rd_chk("R6 neighbour empty", 11, 16'hFFFF);
        wr(16'h0074, 8'h00, 1'b1);
        wr(16'h0099, 8'h14, 1'b0);
        rd_chk("R5 bank II load ignored", 20, 16'hFFFF);
        byte_mode = 1'b1;
        wr(16'h0074, 8'h00, 1'b0);
        wr(16'h00AB, 8'h1F, 1'b0);
        rd_chk("R6 partial byte word 15", 15, 16'hABFF);
        byte_mode = 1'b0;
    endtask

    task automatic t_clear();
        wr(16'h0055, 8'h00, 1'b0);
        wr(16'h0033, 8'h00, 1'b0);
        rd_chk("R9 clear cancelled", 10, 16'h1234);
        wr(16'h0055, 8'h00, 1'b0);
        wr(16'h00D0, 8'h00, 1'b0);
        rd_chk("R9 cleared word 10", 10, 16'hFFFF);
        rd_chk("R9 cleared word 15", 15, 16'hFFFF);
    endtask

    task automatic t_flush();
        wr(16'h0074, 8'h00, 1'b0);
        wr(16'hBEEF, 8'h03, 1'b0);
        wr(16'h000E, 8'h00, 1'b1);
        wr(16'h00D0, 8'h00, 1'b0);
        chk("R7 bank II flush ignored", {15'd0, xfer_req}, 16'd0);
        wr(16'h000E, 8'h00, 1'b0);
        wr(16'h0012, 8'h00, 1'b0);
        chk("R7 flush cancelled", {15'd0, xfer_req}, 16'd0);
        rd_chk("R7 contents kept", 3, 16'hBEEF);
        wr(16'h000E, 8'h00, 1'b0);
        wr(16'h00D0, 8'h00, 1'b0);
        chk("R7 flush raises req", {15'd0, xfer_req}, 16'd1);
        rd_chk("R7 engine reads word 3", 3, 16'hBEEF);
        rd_chk("R6 engine reads unloaded", 4, 16'hFFFF);
        ack();
        rd_chk("R8 cleared after flush", 3, 16'hFFFF);
    endtask

    task automatic t_decode();
        wr(16'h0070, 8'h00, 1'b0);
        chk("R10 unknown code idle", {14'd0, loading, xfer_req}, 16'd0);
        wr(16'hFF41, 8'h00, 1'b0);
        chk("R10 low byte decoded", {15'd0, loading}, 16'd1);
        wr(16'h0000, 8'h07, 1'b0);
        chk("R10 burst left", {15'd0, loading}, 16'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word_burst();
        t_byte_burst();
        t_seq_err();
        t_single();
        t_clear();
        t_flush();
        t_decode();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule